// File: doc/BRIEF.md
# Bootstrap Load Sequencer

This block drives the cold-load procedure of a processor system once an operator load command has been decoded. The command carries a sixteen-bit load-device address. If the system is idle, the sequencer captures that address and walks a fixed, ordered list of steps. It runs a numbered set of self-tests, and each test is preceded by its own system reset pulse. It then issues one more reset and writes zero to every memory word, one word per cycle. Next it asks an image loader to fill two fixed address windows: first the diagnostic image, then the bootstrap image. Finally it switches the system to run mode and asks the processor to start at the diagnostic entry point, and after that at the bootstrap entry point.

Every step other than resets and memory clearing is carried out by an outside unit through a request / done / fail handshake. A request is held until the unit answers. A failing self-test or a failing image load ends the sequence and reports an error code with an element index. A failing diagnostic program parks the processor in a wait state instead of starting the bootstrap. Status outputs keep their values until the next accepted load command.

Top module: `boot_load_seq`

## Requirements
- R1: A load command (`start_req` high) is accepted only when the sequencer is not busy and `sys_idle` is high. In every other cycle it is ignored, and the captured device address does not change. The cycle after an accepted command, `busy` is high.
- R2: Every self-test request is directly preceded by exactly one cycle with `sys_reset` high. After the last test passes, one more single-cycle `sys_reset` precedes memory clearing.
- R3: Self-tests are requested in index order 0 to NUM_TESTS-1. `test_idx` carries the index, and `test_req` stays high with a steady index until `test_done` or `test_fail`.
- R4: A self-test failure ends the sequence, with `err_valid` high, `err_code` = 0xF9 and `err_idx` = the failing test's index. Fail wins when done and fail arrive in the same cycle.
- R5: Memory clearing takes MEM_DEPTH consecutive cycles with `mem_we` high. `mem_addr` counts from 0 upward by one, and `mem_wdata` is zero.
- R6: After clearing, the diagnostic window 0x100..0x1FF is requested (`load_first`/`load_last`), and then the bootstrap window 0x20..0x29. `load_dev` carries the captured device address.
- R7: An image-load failure ends the sequence with `err_code` = 0xF0. `err_idx` is 0 for the diagnostic image and 1 for the bootstrap image, and fail wins over done in the same cycle.
- R8: `run_mode` rises when the bootstrap load completes. The processor is then asked to start at 0x160 (`cpu_addr`), and after its acknowledge at 0x26.
- R9: A diagnostic failure (`cpu_fail` during the 0x160 start; it wins over `cpu_ack`) sets `cpu_wait`. No bootstrap start follows and `seq_done` stays low.
- R10: `seq_done` rises after the processor acknowledges the bootstrap start. `seq_done`, `err_valid`, `err_code`, `err_idx`, `cpu_wait` and `run_mode` hold until the next accepted command, which clears them.
- R11: During reset, every request, strobe and status output is low and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Decoded load command |
| dev_addr | input | 16 | Load-device address carried by the command |
| sys_idle | input | 1 | System is in its idle state |
| sys_reset | output | 1 | Single-cycle system reset pulse |
| test_req | output | 1 | Self-test request |
| test_idx | output | 4 | Index of the requested self-test |
| test_done | input | 1 | Self-test passed |
| test_fail | input | 1 | Self-test failed |
| mem_we | output | 1 | Memory clear write strobe |
| mem_addr | output | ADDR_W | Memory clear address |
| mem_wdata | output | DATA_W | Memory clear data (zero) |
| load_req | output | 1 | Image load request |
| load_first | output | ADDR_W | First address of the image window |
| load_last | output | ADDR_W | Last address of the image window |
| load_dev | output | 16 | Captured load-device address |
| load_done | input | 1 | Image load finished |
| load_fail | input | 1 | Image load error |
| run_mode | output | 1 | System placed in run mode |
| cpu_start | output | 1 | Processor start request |
| cpu_addr | output | ADDR_W | Processor start address |
| cpu_ack | input | 1 | Processor accepted / program completed |
| cpu_fail | input | 1 | Diagnostic program reported failure |
| cpu_wait | output | 1 | Processor parked in wait state |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Sequence completed successfully |
| err_valid | output | 1 | Sequence aborted with an error |
| err_code | output | 8 | Error code (0xF9 test, 0xF0 load) |
| err_idx | output | 4 | Failing element index |

## Verification
A unit's done and fail answers can arrive in the same cycle. The bench raises both together in a self-test, in an image load and in the diagnostic start. It then judges that the error or wait outcome was taken, that no later step was requested, and that no success was reported. A new load command can also coincide with an active sequence: the bench raises one in the middle of memory clearing, while offering a different device address, and checks that the clear count, the request order and the address later shown on `load_dev` are all unchanged.

// File: rtl/bls_pkg.sv
// Package: shared state encoding and fixed codes of the bootstrap load sequencer.
// Assumes: consumers import it; no parameters live here.
package bls_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TRST,
        ST_TREQ,
        ST_FRST,
        ST_CLR,
        ST_LDIAG,
        ST_LBOOT,
        ST_RDIAG,
        ST_RBOOT
    } bls_state_e;

    localparam logic [7:0] ERR_TEST = 8'hF9;
    localparam logic [7:0] ERR_LOAD = 8'hF0;

endpackage

// File: rtl/bls_counter.sv
// Module: bls_counter
// Up-counter with synchronous clear and a flag for the terminal value LAST.
// Assumes: LAST fits in W bits; counting past LAST simply wraps.
module bls_counter #(
    parameter int W    = 4,
    parameter int LAST = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         at_last
);

    // Count register: clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   val <= '0;
        else if (clr) val <= '0;
        else if (inc) val <= val + W'(1);
    end

    // Terminal value detect.
    always_comb at_last = (val == W'(LAST));

endmodule

// File: rtl/bls_fsm.sv
// Module: bls_fsm
// Step sequencer and status registers of the bootstrap load sequence.
// Assumes: unit answers are sampled only in the state that requested them;
// fail always wins over done when both arrive in one cycle.
module bls_fsm
    import bls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       sys_idle,
    input  logic       test_done,
    input  logic       test_fail,
    input  logic       test_last,
    input  logic [3:0] test_idx,
    input  logic       clr_last,
    input  logic       load_done,
    input  logic       load_fail,
    input  logic       cpu_ack,
    input  logic       cpu_fail,
    output bls_state_e state,
    output logic       accept,
    output logic       t_clr,
    output logic       t_inc,
    output logic       c_clr,
    output logic       c_inc,
    output logic       run_mode,
    output logic       cpu_wait,
    output logic       seq_done,
    output logic       err_valid,
    output logic [7:0] err_code,
    output logic [3:0] err_idx
);

    bls_state_e nxt;

    // Next-state and counter-control decode.
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        t_clr  = 1'b0;
        t_inc  = 1'b0;
        c_clr  = 1'b0;
        c_inc  = 1'b0;
        case (state)
            ST_IDLE: if (start_req && sys_idle) begin
                accept = 1'b1;
                t_clr  = 1'b1;
                nxt    = ST_TRST;
            end
            ST_TRST: nxt = ST_TREQ;
            ST_TREQ: begin
                if (test_fail) nxt = ST_IDLE;
                else if (test_done) begin
                    if (test_last) nxt = ST_FRST;
                    else begin
                        t_inc = 1'b1;
                        nxt   = ST_TRST;
                    end
                end
            end
            ST_FRST: begin
                c_clr = 1'b1;
                nxt   = ST_CLR;
            end
            ST_CLR: begin
                c_inc = 1'b1;
                if (clr_last) nxt = ST_LDIAG;
            end
            ST_LDIAG: begin
                if (load_fail)      nxt = ST_IDLE;
                else if (load_done) nxt = ST_LBOOT;
            end
            ST_LBOOT: begin
                if (load_fail)      nxt = ST_IDLE;
                else if (load_done) nxt = ST_RDIAG;
            end
            ST_RDIAG: begin
                if (cpu_fail)     nxt = ST_IDLE;
                else if (cpu_ack) nxt = ST_RBOOT;
            end
            ST_RBOOT: if (cpu_ack) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Status registers: cleared on acceptance, set by the step that ends the run.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            run_mode  <= 1'b0;
            cpu_wait  <= 1'b0;
            seq_done  <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= '0;
            err_idx   <= '0;
        end else begin
            case (state)
                ST_TREQ: if (test_fail) begin
                    err_valid <= 1'b1;
                    err_code  <= ERR_TEST;
                    err_idx   <= test_idx;
                end
                ST_LDIAG: if (load_fail) begin
                    err_valid <= 1'b1;
                    err_code  <= ERR_LOAD;
                    err_idx   <= 4'd0;
                end
                ST_LBOOT: begin
                    if (load_fail) begin
                        err_valid <= 1'b1;
                        err_code  <= ERR_LOAD;
                        err_idx   <= 4'd1;
                    end else if (load_done) begin
                        run_mode <= 1'b1;
                    end
                end
                ST_RDIAG: if (cpu_fail) cpu_wait <= 1'b1;
                ST_RBOOT: if (cpu_ack)  seq_done <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/boot_load_seq.sv
// Module: boot_load_seq (top)
// Runs self-tests with per-test resets, clears memory, loads two images into
// fixed windows, then starts the processor at two chained entry points.
// Assumes: NUM_TESTS <= 16, MEM_DEPTH <= 2**ADDR_W, windows fit in ADDR_W.
module boot_load_seq
    import bls_pkg::*;
#(
    parameter int NUM_TESTS  = 4,
    parameter int MEM_DEPTH  = 512,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DIAG_LO    = 'h100,
    parameter int DIAG_HI    = 'h1FF,
    parameter int DIAG_ENTRY = 'h160,
    parameter int BOOT_LO    = 'h20,
    parameter int BOOT_HI    = 'h29,
    parameter int BOOT_ENTRY = 'h26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [15:0]       dev_addr,
    input  logic              sys_idle,
    output logic              sys_reset,
    output logic              test_req,
    output logic [3:0]        test_idx,
    input  logic              test_done,
    input  logic              test_fail,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              load_req,
    output logic [ADDR_W-1:0] load_first,
    output logic [ADDR_W-1:0] load_last,
    output logic [15:0]       load_dev,
    input  logic              load_done,
    input  logic              load_fail,
    output logic              run_mode,
    output logic              cpu_start,
    output logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_ack,
    input  logic              cpu_fail,
    output logic              cpu_wait,
    output logic              busy,
    output logic              seq_done,
    output logic              err_valid,
    output logic [7:0]        err_code,
    output logic [3:0]        err_idx
);

    localparam int IDX_W = 4;

    bls_state_e  state;
    logic        accept, t_clr, t_inc, c_clr, c_inc, test_last, clr_last;
    logic [15:0] dev_q;

    bls_counter #(.W(IDX_W), .LAST(NUM_TESTS - 1)) u_test_cnt (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc),
        .val(test_idx), .at_last(test_last)
    );

    bls_counter #(.W(ADDR_W), .LAST(MEM_DEPTH - 1)) u_clr_cnt (
        .clk(clk), .rst_n(rst_n), .clr(c_clr), .inc(c_inc),
        .val(mem_addr), .at_last(clr_last)
    );

    bls_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .sys_idle(sys_idle),
        .test_done(test_done), .test_fail(test_fail), .test_last(test_last),
        .test_idx(test_idx), .clr_last(clr_last),
        .load_done(load_done), .load_fail(load_fail),
        .cpu_ack(cpu_ack), .cpu_fail(cpu_fail),
        .state(state), .accept(accept),
        .t_clr(t_clr), .t_inc(t_inc), .c_clr(c_clr), .c_inc(c_inc),
        .run_mode(run_mode), .cpu_wait(cpu_wait), .seq_done(seq_done),
        .err_valid(err_valid), .err_code(err_code), .err_idx(err_idx)
    );

    // Capture the load-device address on an accepted command only.
    always_ff @(posedge clk) begin
        if (!rst_n)      dev_q <= '0;
        else if (accept) dev_q <= dev_addr;
    end

    // Handshake and strobe outputs decoded from the current step.
    always_comb begin
        sys_reset  = (state == ST_TRST) || (state == ST_FRST);
        test_req   = (state == ST_TREQ);
        mem_we     = (state == ST_CLR);
        mem_wdata  = '0;
        load_req   = (state == ST_LDIAG) || (state == ST_LBOOT);
        load_first = (state == ST_LBOOT) ? ADDR_W'(BOOT_LO) : ADDR_W'(DIAG_LO);
        load_last  = (state == ST_LBOOT) ? ADDR_W'(BOOT_HI) : ADDR_W'(DIAG_HI);
        load_dev   = dev_q;
        cpu_start  = (state == ST_RDIAG) || (state == ST_RBOOT);
        cpu_addr   = (state == ST_RBOOT) ? ADDR_W'(BOOT_ENTRY) : ADDR_W'(DIAG_ENTRY);
        busy       = (state != ST_IDLE);
    end

endmodule

// File: rtl/bls_checker.sv
// Module: bls_checker
// Temporal properties of boot_load_seq, attached by the bind below.
// Assumes: only top-level ports are observed.
module bls_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_req,
    input logic              sys_idle,
    input logic              sys_reset,
    input logic              test_req,
    input logic [3:0]        test_idx,
    input logic              test_done,
    input logic              test_fail,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              load_req,
    input logic              cpu_start,
    input logic              run_mode,
    input logic              cpu_wait,
    input logic              busy,
    input logic              seq_done,
    input logic              err_valid,
    input logic [7:0]        err_code
);

    p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && !sys_idle) |=> !busy);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && sys_idle) |=> (busy && sys_reset));

    p_reset_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> (test_req || mem_we));

    p_one_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_reset, test_req, mem_we, load_req, cpu_start}));

    p_test_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_done && !test_fail) |=> (test_req && $stable(test_idx)));

    p_err_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code == 8'hF9 || err_code == 8'hF0));

    p_mem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    p_run_before_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> run_mode);

    p_wait_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (!seq_done && !cpu_start));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && err_valid));

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start_req && sys_idle)) |=>
        ($stable(seq_done) && $stable(err_valid) && $stable(cpu_wait) && $stable(run_mode)));

endmodule

bind boot_load_seq bls_checker #(.ADDR_W(ADDR_W)) u_bls_checker (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sys_idle(sys_idle),
    .sys_reset(sys_reset), .test_req(test_req), .test_idx(test_idx),
    .test_done(test_done), .test_fail(test_fail), .mem_we(mem_we),
    .mem_addr(mem_addr), .load_req(load_req), .cpu_start(cpu_start),
    .run_mode(run_mode), .cpu_wait(cpu_wait), .busy(busy),
    .seq_done(seq_done), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/test_boot_load_seq.sv
// Bench: a behavioural per-cycle trace (stimulus + expected outputs) is built
// in a queue from the requirements and compared against the ports each cycle.
module test_boot_load_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 4;
    localparam int DEPTH      = 512;
    localparam int AW         = 12;
    localparam int DW         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0, sys_idle = 1'b0;
    logic [15:0]   dev_addr = '0;
    logic          test_done = 1'b0, test_fail = 1'b0;
    logic          load_done = 1'b0, load_fail = 1'b0;
    logic          cpu_ack = 1'b0, cpu_fail = 1'b0;
    logic          sys_reset, test_req, mem_we, load_req, run_mode, cpu_start;
    logic          cpu_wait, busy, seq_done, err_valid;
    logic [3:0]    test_idx, err_idx;
    logic [AW-1:0] mem_addr, load_first, load_last, cpu_addr;
    logic [DW-1:0] mem_wdata;
    logic [15:0]   load_dev;
    logic [7:0]    err_code;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_load_seq #(.NUM_TESTS(NT), .MEM_DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_boot_load_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .dev_addr(dev_addr),
        .sys_idle(sys_idle), .sys_reset(sys_reset), .test_req(test_req),
        .test_idx(test_idx), .test_done(test_done), .test_fail(test_fail),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .load_req(load_req), .load_first(load_first), .load_last(load_last),
        .load_dev(load_dev), .load_done(load_done), .load_fail(load_fail),
        .run_mode(run_mode), .cpu_start(cpu_start), .cpu_addr(cpu_addr),
        .cpu_ack(cpu_ack), .cpu_fail(cpu_fail), .cpu_wait(cpu_wait),
        .busy(busy), .seq_done(seq_done), .err_valid(err_valid),
        .err_code(err_code), .err_idx(err_idx)
    );

    typedef struct {
        int st, idl, dev, td, tf, ld, lf, ca, cf;          // stimulus
        int rp, tr, ti, we, ad, lr, lfst, llst, ldev;      // expected
        int cs, caddr, run, bz, dn, ev, code, eidx, wt;
    } ent_t;

    ent_t q[$];
    ent_t e;
    int   s_run, s_done, s_err, s_code, s_idx, s_wait, s_dev;
    int   n_cmp = 0, n_bad = 0;
    bit   finished = 1'b0;

    task automatic blank();
        e = '{default: 0};
        e.bz = 1; e.dev = 16'h0F0F;
        e.run = s_run; e.dn = s_done; e.ev = s_err; e.code = s_code;
        e.eidx = s_idx; e.wt = s_wait; e.ldev = s_dev;
    endtask

    task automatic push();
        q.push_back(e);
    endtask

    // One full load attempt: fl_t/fl_l pick a failing test/load (-1 = none),
    // both_x raises done together with fail, lat = cycles before each answer.
    task automatic build(input int dev, input int lat, input int fl_t, input bit both_t,
                         input int fl_l, input bit both_l, input bit dfail, input int poke);
        blank(); e.bz = 0; e.st = 1; e.idl = 1; e.dev = dev; push();
        s_run = 0; s_done = 0; s_err = 0; s_code = 0; s_idx = 0; s_wait = 0; s_dev = dev;
        for (int t = 0; t < NT; t++) begin
            blank(); e.rp = 1; push();
            for (int k = 0; k < lat; k++) begin blank(); e.tr = 1; e.ti = t; e.ld = 1; push(); end
            blank(); e.tr = 1; e.ti = t;
            if (t == fl_t) begin
                e.tf = 1; e.td = both_t; push();
                s_err = 1; s_code = 'hF9; s_idx = t;
                return;
            end
            e.td = 1; push();
        end
        blank(); e.rp = 1; push();
        for (int a = 0; a < DEPTH; a++) begin
            blank(); e.we = 1; e.ad = a;
            if (a == poke) begin e.st = 1; e.idl = 1; e.dev = 16'hDEAD; end
            push();
        end
        for (int im = 0; im < 2; im++) begin
            for (int k = 0; k <= lat; k++) begin
                blank(); e.lr = 1;
                e.lfst = (im == 0) ? 'h100 : 'h20;
                e.llst = (im == 0) ? 'h1FF : 'h29;
                if (k < lat) begin e.ca = 1; push(); continue; end
                if (im == fl_l) begin
                    e.lf = 1; e.ld = both_l; push();
                    s_err = 1; s_code = 'hF0; s_idx = im;
                    return;
                end
                e.ld = 1; push();
            end
        end
        s_run = 1;
        for (int k = 0; k <= lat; k++) begin
            blank(); e.cs = 1; e.caddr = 'h160;
            if (k == lat) begin
                if (dfail) begin e.cf = 1; e.ca = 1; push(); s_wait = 1; return; end
                e.ca = 1;
            end
            push();
        end
        for (int k = 0; k <= lat; k++) begin
            blank(); e.cs = 1; e.caddr = 'h26;
            if (k == lat) e.ca = 1;
            push();
        end
        s_done = 1;
    endtask

    // Idle tail: a command without sys_idle must be ignored, status held.
    task automatic tail();
        blank(); e.bz = 0; push();
        blank(); e.bz = 0; e.st = 1; e.idl = 0; e.dev = 16'h5555; push();
        blank(); e.bz = 0; push();
        blank(); e.bz = 0; push();
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input ent_t x, input string pre);
        chk({pre, "R2 sys_reset"}, int'(sys_reset), x.rp);
        chk({pre, "R3 test_req"}, int'(test_req), x.tr);
        if (x.tr != 0) chk({pre, "R3 test_idx"}, int'(test_idx), x.ti);
        chk({pre, "R5 mem_we"}, int'(mem_we), x.we);
        if (x.we != 0) begin
            chk({pre, "R5 mem_addr"}, int'(mem_addr), x.ad);
            chk({pre, "R5 mem_wdata"}, int'(mem_wdata != '0), 0);
        end
        chk({pre, "R6 load_req"}, int'(load_req), x.lr);
        if (x.lr != 0) begin
            chk({pre, "R6 load_first"}, int'(load_first), x.lfst);
            chk({pre, "R6 load_last"}, int'(load_last), x.llst);
            chk({pre, "R1 load_dev"}, int'(load_dev), x.ldev);
        end
        chk({pre, "R8 cpu_start"}, int'(cpu_start), x.cs);
        if (x.cs != 0) chk({pre, "R8 cpu_addr"}, int'(cpu_addr), x.caddr);
        chk({pre, "R8 run_mode"}, int'(run_mode), x.run);
        chk({pre, "R1 busy"}, int'(busy), x.bz);
        chk({pre, "R10 seq_done"}, int'(seq_done), x.dn);
        chk({pre, "R4 err_valid"}, int'(err_valid), x.ev);
        if (x.ev != 0) begin
            chk({pre, (x.code == 'hF0) ? "R7 err_code" : "R4 err_code"}, int'(err_code), x.code);
            chk({pre, (x.code == 'hF0) ? "R7 err_idx" : "R4 err_idx"}, int'(err_idx), x.eidx);
        end
        chk({pre, "R9 cpu_wait"}, int'(cpu_wait), x.wt);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        s_run = 0; s_done = 0; s_err = 0; s_code = 0; s_idx = 0; s_wait = 0; s_dev = 0;
        build(16'hA5C3, 0, -1, 0, -1, 0, 0, 100);  tail();   // full pass, mid-run command ignored
        build(16'h1234, 2, -1, 0, -1, 0, 0, -1);   tail();   // full pass with latency
        build(16'h0042, 0, 0, 1, -1, 0, 0, -1);    tail();   // first test: done+fail together
        build(16'h7777, 1, NT - 1, 0, -1, 0, 0, -1); tail(); // last test fails
        build(16'h00C8, 1, -1, 0, 0, 1, 0, -1);    tail();   // diag load: done+fail together
        build(16'hBEEF, 0, -1, 0, 1, 0, 0, -1);    tail();   // boot load fails
        build(16'h3C3C, 1, -1, 0, -1, 0, 1, -1);   tail();   // diag program fails, ack also high
        build(16'h9001, 0, -1, 0, -1, 0, 0, 7);    tail();   // clears earlier status
        // Reset state, with a command offered during reset (R11).
        start_req = 1'b1; sys_idle = 1'b1; dev_addr = 16'hFFFF;
        repeat (3) @(negedge clk);
        blank(); e.bz = 0; e.run = 0; e.dn = 0; e.ev = 0; e.wt = 0;
        cmp_all(e, "R11/");
        start_req = 1'b0; sys_idle = 1'b0;
        @(negedge clk);
        cmp_all(e, "R11/");
        rst_n = 1'b1;
        while (q.size() > 0) begin
            ent_t x;
            @(negedge clk);
            x = q.pop_front();
            cmp_all(x, "");
            start_req = x.st[0]; sys_idle = x.idl[0]; dev_addr = x.dev[15:0];
            test_done = x.td[0]; test_fail = x.tf[0];
            load_done = x.ld[0]; load_fail = x.lf[0];
            cpu_ack = x.ca[0]; cpu_fail = x.cf[0];
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

endmodule